// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-facing front end of a peripheral controller that sits on a simple I/O bus. The host does not address each internal register directly. It first writes a register index into a pointer port, then reads or writes a data port. There are two data ports. One reaches the control/status register bank and the other reaches the configuration register bank. The single stored pointer indexes both banks, so once the pointer holds N, the two data ports reach register N of their own banks.

The block decodes the bus offset. The offsets move between a 16-bit (word) and a 32-bit (doubleword) I/O mode, and a static mode input picks between them. The block holds the 8-bit pointer and turns each data-port access into a one-cycle read or write strobe to the selected bank. That strobe carries the pointer index and the write data.

Bank read data returns combinationally during the strobe cycle. The block registers it onto the bus read data, which is valid one cycle after the access. Two sources clear the pointer: the hardware reset and a software reset input. The controller's stop control does not affect the pointer.

Top module: `ioreg_window`

## Requirements
- R1: After `rst`, the pointer holds 0, no bank strobe is active while `bus_en` is low, and `bus_rdata` is 0.
- R2: A pointer write stores `bus_wdata[7:0]`. Bits 31:8 of the written value are ignored, and a pointer read returns the index in bits 7:0 with all higher bits zero.
- R3: In word mode (`dw_mode`=0), the pointer port is at offset 0x12, the control/status data port is at 0x10, and the configuration data port is at 0x16.
- R4: In doubleword mode (`dw_mode`=1), the pointer port is at offset 0x14, the control/status data port is at 0x10, and the configuration data port is at 0x1C.
- R5: With the pointer at N, a control/status data-port access reaches control/status register N, and a configuration data-port access reaches configuration register N.
- R6: In any cycle with `bus_en` high at a data port, exactly one of `csr_rd`, `csr_wr`, `cfg_rd`, `cfg_wr` is high, with `reg_idx` equal to the pointer. No strobe is ever high while `bus_en` is low.
- R7: In word mode, bank write data carries `bus_wdata[15:0]` with bits 31:16 forced to zero, and bus read data has bits 31:16 zero. In doubleword mode, all 32 bits pass through.
- R8: An access at an offset not assigned in the active mode produces no strobe and leaves the pointer unchanged. A read of such an offset returns 0.
- R9: `sw_rst` clears the pointer on the next clock edge and takes priority over a simultaneous pointer write. `stop` leaves the pointer unchanged.
- R10: `bus_rdata` is registered. One cycle after a read access, it shows that read's value. One cycle after any cycle without a read access, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, clears the pointer |
| stop | input | 1 | Controller stop control; no effect on this block |
| dw_mode | input | 1 | 0 = word I/O offsets, 1 = doubleword I/O offsets |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_off | input | 5 | Bus port offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| reg_idx | output | 8 | Pointer value, the register index for both banks |
| reg_wdata | output | 32 | Write data to the banks, width-shaped by mode |
| csr_rd | output | 1 | Control/status bank read strobe |
| csr_wr | output | 1 | Control/status bank write strobe |
| csr_rdata | input | 32 | Control/status bank read data, combinational |
| cfg_rd | output | 1 | Configuration bank read strobe |
| cfg_wr | output | 1 | Configuration bank write strobe |
| cfg_rdata | input | 32 | Configuration bank read data, combinational |

## Verification
Directed sequences load the pointer and then reach both banks through it. This shows that one shared index selects register N in each space, not two independent pointers. The same offsets are then tried in both modes. For example, 0x14 is the pointer port in doubleword mode but unassigned in word mode, which separates a correct mode-dependent decode from a merged one. Writes carrying all-ones in bits 31:8 and in bits 31:16 expose pointer reserved-bit leakage and word-mode truncation faults. Constrained-random traffic mixes modes, assigned and unassigned offsets, reads, writes, idle cycles, stop and software resets, all compared against a bench model of the pointer and both banks.

// File: rtl/iow_pkg.sv
package iow_pkg;

  // Port selected by the current bus offset
  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_PTR  = 2'd1,
    PORT_CSR  = 2'd2,
    PORT_CFG  = 2'd3
  } port_e;

  // Offsets in word I/O mode
  localparam int W_PTR_OFF  = 'h12;
  localparam int W_CSR_OFF  = 'h10;
  localparam int W_CFG_OFF  = 'h16;

  // Offsets in doubleword I/O mode
  localparam int DW_PTR_OFF = 'h14;
  localparam int DW_CSR_OFF = 'h10;
  localparam int DW_CFG_OFF = 'h1C;

  localparam int N_MODES = 2;

endpackage

// File: rtl/iow_decode.sv
module iow_decode
  import iow_pkg::*;
#(
  parameter int OFF_W = 5
) (
  input  logic [OFF_W-1:0] off,
  input  logic             dw_mode,
  output port_e            sel
);

  // One decoder per I/O mode; the mode input picks the active one
  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    localparam logic [OFF_W-1:0] PTR_AT = OFF_W'((m == 1) ? DW_PTR_OFF : W_PTR_OFF);
    localparam logic [OFF_W-1:0] CSR_AT = OFF_W'((m == 1) ? DW_CSR_OFF : W_CSR_OFF);
    localparam logic [OFF_W-1:0] CFG_AT = OFF_W'((m == 1) ? DW_CFG_OFF : W_CFG_OFF);
    port_e hit;
    always_comb begin
      if (off == PTR_AT)      hit = PORT_PTR;
      else if (off == CSR_AT) hit = PORT_CSR;
      else if (off == CFG_AT) hit = PORT_CFG;
      else                    hit = PORT_NONE;
    end
  end

  assign sel = dw_mode ? g_mode[1].hit : g_mode[0].hit;

endmodule

// File: rtl/iow_ptr.sv
module iow_ptr #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             load,
  input  logic [IDX_W-1:0] din,
  output logic [IDX_W-1:0] idx
);

  // Both resets win over a load in the same cycle
  always_ff @(posedge clk) begin
    if (rst || sw_rst) idx <= '0;
    else if (load)     idx <= din;
  end

endmodule

// File: rtl/iow_path.sv
module iow_path
  import iow_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dw_mode,
  input  logic              bus_en,
  input  logic              bus_we,
  input  port_e             sel,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] csr_rdata,
  input  logic [DATA_W-1:0] cfg_rdata,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              csr_rd,
  output logic              csr_wr,
  output logic              cfg_rd,
  output logic              cfg_wr,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int HALF_W = DATA_W / 2;
  localparam int UP_W   = DATA_W - HALF_W;
  localparam int PAD_W  = DATA_W - IDX_W;

  logic              rd_cyc;
  logic              wr_cyc;
  logic [DATA_W-1:0] raw_rd;
  logic [DATA_W-1:0] shaped_rd;

  assign rd_cyc = bus_en && !bus_we;
  assign wr_cyc = bus_en &&  bus_we;

  // Bank strobes, live only during the access cycle
  assign csr_rd = rd_cyc && (sel == PORT_CSR);
  assign csr_wr = wr_cyc && (sel == PORT_CSR);
  assign cfg_rd = rd_cyc && (sel == PORT_CFG);
  assign cfg_wr = wr_cyc && (sel == PORT_CFG);

  // Word mode narrows the data path to its lower half
  assign reg_wdata = dw_mode ? bus_wdata : {{UP_W{1'b0}}, bus_wdata[HALF_W-1:0]};

  always_comb begin
    unique case (sel)
      PORT_PTR: raw_rd = {{PAD_W{1'b0}}, idx};
      PORT_CSR: raw_rd = csr_rdata;
      PORT_CFG: raw_rd = cfg_rdata;
      default:  raw_rd = '0;
    endcase
  end

  assign shaped_rd = dw_mode ? raw_rd : {{UP_W{1'b0}}, raw_rd[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_cyc) bus_rdata <= shaped_rd;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/ioreg_window.sv
module ioreg_window
  import iow_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              stop,
  input  logic              dw_mode,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              csr_rd,
  output logic              csr_wr,
  input  logic [DATA_W-1:0] csr_rdata,
  output logic              cfg_rd,
  output logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_rdata
);

  port_e sel;
  logic  ptr_load;
  logic  unused_stop;

  // The stop control deliberately has no path into the pointer
  assign unused_stop = stop;

  iow_decode #(.OFF_W(OFF_W)) u_decode (
    .off     (bus_off),
    .dw_mode (dw_mode),
    .sel     (sel)
  );

  assign ptr_load = bus_en && bus_we && (sel == PORT_PTR);

  iow_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .sw_rst (sw_rst),
    .load   (ptr_load),
    .din    (bus_wdata[IDX_W-1:0]),
    .idx    (reg_idx)
  );

  iow_path #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .dw_mode   (dw_mode),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .sel       (sel),
    .bus_wdata (bus_wdata),
    .idx       (reg_idx),
    .csr_rdata (csr_rdata),
    .cfg_rdata (cfg_rdata),
    .reg_wdata (reg_wdata),
    .csr_rd    (csr_rd),
    .csr_wr    (csr_wr),
    .cfg_rd    (cfg_rd),
    .cfg_wr    (cfg_wr),
    .bus_rdata (bus_rdata)
  );

endmodule

// File: rtl/iow_checker.sv
module iow_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_rst,
  input logic              dw_mode,
  input logic              bus_en,
  input logic              bus_we,
  input logic [OFF_W-1:0]  bus_off,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              csr_rd,
  input logic              csr_wr,
  input logic              cfg_rd,
  input logic              cfg_wr
);

  localparam int HALF_W = DATA_W / 2;

  logic any_strobe;
  logic ptr_hit;
  logic known_off;

  assign any_strobe = csr_rd || csr_wr || cfg_rd || cfg_wr;
  assign ptr_hit    = dw_mode ? (bus_off == OFF_W'('h14)) : (bus_off == OFF_W'('h12));
  assign known_off  = ptr_hit || (bus_off == OFF_W'('h10)) ||
                      (dw_mode ? (bus_off == OFF_W'('h1C)) : (bus_off == OFF_W'('h16)));

  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({csr_rd, csr_wr, cfg_rd, cfg_wr}));

  // R6
  strobe_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    any_strobe |-> bus_en);

  // R8
  unassigned_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !known_off) |-> !any_strobe);

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(bus_en && bus_we && ptr_hit) && !sw_rst) |=> $stable(reg_idx));

  // R9
  swrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (reg_idx == '0));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> (bus_rdata == '0));

  // R7
  word_trunc_chk: assert property (@(posedge clk) disable iff (rst)
    (!dw_mode && (csr_wr || cfg_wr)) |-> (reg_wdata[DATA_W-1:HALF_W] == '0));

  // R7
  word_read_chk: assert property (@(posedge clk) disable iff (rst)
    !dw_mode |=> (bus_rdata[DATA_W-1:HALF_W] == '0));

endmodule

bind ioreg_window iow_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/ioreg_window_test.sv
module ioreg_window_test;

  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_rst = 1'b0;
  logic        stop = 1'b0;
  logic        dw_mode = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_off = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic        csr_rd, csr_wr, cfg_rd, cfg_wr;
  logic [31:0] csr_rdata, cfg_rdata;

  logic [31:0] csr_mem [256];
  logic [31:0] cfg_mem [256];
  logic [31:0] exp_csr [256];
  logic [31:0] exp_cfg [256];
  logic [7:0]  ptr_m = '0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_T/2) clk = ~clk;

  ioreg_window uut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .stop(stop), .dw_mode(dw_mode),
    .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_rdata(csr_rdata),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata)
  );

  // Stub banks
  assign csr_rdata = csr_mem[reg_idx];
  assign cfg_rdata = cfg_mem[reg_idx];
  always @(posedge clk) begin
    if (csr_wr) csr_mem[reg_idx] <= reg_wdata;
    if (cfg_wr) cfg_mem[reg_idx] <= reg_wdata;
  end

  // 0 none, 1 pointer, 2 control/status, 3 configuration
  function automatic int port_of(bit dw, logic [4:0] off);
    if (off == 5'h10) return 2;
    if (dw) begin
      if (off == 5'h14) return 1;
      if (off == 5'h1C) return 3;
    end else begin
      if (off == 5'h12) return 1;
      if (off == 5'h16) return 3;
    end
    return 0;
  endfunction

  function automatic logic [31:0] shape(bit dw, logic [31:0] v);
    return dw ? v : {16'h0, v[15:0]};
  endfunction

  task automatic chk(string tag, bit ok, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic access(bit dw, bit en, bit we, logic [4:0] off, logic [31:0] wd,
                        bit sw, bit st, string tag);
    int          p;
    logic [3:0]  exp_stb;
    logic [31:0] exp_rd;
    @(negedge clk);
    dw_mode = dw; bus_en = en; bus_we = we; bus_off = off;
    bus_wdata = wd; sw_rst = sw; stop = st;
    #1;
    p = en ? port_of(dw, off) : 0;
    exp_stb = {(p == 2) && !we, (p == 2) && we, (p == 3) && !we, (p == 3) && we};
    chk({tag, " R6 strobes"}, {csr_rd, csr_wr, cfg_rd, cfg_wr} == exp_stb,
        64'({csr_rd, csr_wr, cfg_rd, cfg_wr}), 64'(exp_stb));
    if (p >= 2)
      chk({tag, " R5 index"}, reg_idx == ptr_m, 64'(reg_idx), 64'(ptr_m));
    if (p >= 2 && we)
      chk({tag, " R7 wdata"}, reg_wdata == shape(dw, wd), 64'(reg_wdata), 64'(shape(dw, wd)));
    exp_rd = '0;
    if (en && !we) begin
      case (p)
        1: exp_rd = {24'h0, ptr_m};
        2: exp_rd = exp_csr[ptr_m];
        3: exp_rd = exp_cfg[ptr_m];
        default: exp_rd = '0;
      endcase
      exp_rd = shape(dw, exp_rd);
    end
    @(posedge clk);
    #1;
    chk({tag, " R10 rdata"}, bus_rdata == exp_rd, 64'(bus_rdata), 64'(exp_rd));
    if (en && we && p == 2) exp_csr[ptr_m] = shape(dw, wd);
    if (en && we && p == 3) exp_cfg[ptr_m] = shape(dw, wd);
    if (sw) ptr_m = '0;
    else if (en && we && p == 1) ptr_m = wd[7:0];
  endtask

  initial begin
    #(CLK_T * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      csr_mem[i] = 32'hC5A0_0000 ^ (i * 32'h0101_0101);
      cfg_mem[i] = 32'h3B70_0000 ^ (i * 32'h0011_0203);
      exp_csr[i] = csr_mem[i];
      exp_cfg[i] = cfg_mem[i];
    end
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 rdata", bus_rdata == 32'h0, 64'(bus_rdata), 64'h0);
    chk("R1 pointer", reg_idx == 8'h0, 64'(reg_idx), 64'h0);
    access(0, 1, 0, 5'h12, 32'h0, 0, 0, "R1");

    // R2: reserved pointer bits
    access(1, 1, 1, 5'h14, 32'hFFFF_FF5A, 0, 0, "R2");
    access(1, 1, 0, 5'h14, 32'h0, 0, 0, "R2");
    // R7: word mode truncation
    access(0, 1, 1, 5'h10, 32'hABCD_1234, 0, 0, "R7");
    access(0, 1, 0, 5'h10, 32'h0, 0, 0, "R7");
    access(1, 1, 0, 5'h10, 32'h0, 0, 0, "R5");
    // R4 / R5 / R3: configuration space through the same pointer
    access(1, 1, 1, 5'h1C, 32'hDEAD_BEEF, 0, 0, "R4");
    access(1, 1, 0, 5'h1C, 32'h0, 0, 0, "R5");
    access(0, 1, 0, 5'h16, 32'h0, 0, 0, "R3");
    access(0, 1, 1, 5'h12, 32'hFFFF_0033, 0, 0, "R3");
    access(0, 1, 0, 5'h12, 32'h0, 0, 0, "R3");
    access(1, 1, 0, 5'h16, 32'h0, 0, 0, "R4");
    // R8: unassigned offsets in the active mode
    access(1, 1, 1, 5'h18, 32'h0000_0077, 0, 0, "R8");
    access(0, 1, 1, 5'h14, 32'h0000_0077, 0, 0, "R8");
    access(0, 1, 1, 5'h1C, 32'h0000_0077, 0, 0, "R8");
    access(0, 1, 0, 5'h18, 32'h0, 0, 0, "R8");
    access(0, 1, 0, 5'h12, 32'h0, 0, 0, "R8");
    // R6: no strobe without bus_en
    access(0, 0, 1, 5'h10, 32'h1111_1111, 0, 0, "R6");
    access(0, 1, 0, 5'h10, 32'h0, 0, 0, "R6");
    // R9: stop keeps pointer, software reset clears it and beats a load
    access(0, 0, 0, 5'h0, 32'h0, 0, 1, "R9");
    access(0, 1, 0, 5'h12, 32'h0, 0, 1, "R9");
    access(1, 1, 1, 5'h14, 32'h0000_00AA, 1, 0, "R9");
    access(1, 1, 0, 5'h14, 32'h0, 0, 0, "R9");

    // Constrained-random traffic
    for (int n = 0; n < 800; n++) begin
      bit          dw;
      logic [4:0]  off;
      int          r;
      dw = 1'($urandom % 2);
      r  = $urandom % 8;
      case (r)
        0: off = 5'h10;
        1: off = 5'h12;
        2: off = 5'h14;
        3: off = 5'h16;
        4: off = 5'h1C;
        5: off = dw ? 5'h14 : 5'h12;
        default: off = 5'($urandom);
      endcase
      access(dw, ($urandom % 6) != 0, 1'($urandom % 2), off, $urandom,
             ($urandom % 50) == 0, 1'($urandom % 2), "R5");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule